// File: doc/BRIEF.md
# Segmented Multi-Queue Ring Buffer

This block keeps many independent FIFO queues inside one shared on-chip message store. Each queue is given a contiguous run of fixed-size chunks inside a single region of the store. The region is chosen by a small base field. The run is bounded by a first and a last chunk index that share the region's upper address bits, so a queue can never straddle two regions. Software loads a 64-bit configuration word per queue. The block then serves push and pop requests by queue number: it forms the physical store address from the queue's write or read offset, moves the data, and advances that offset. When the offset steps past the final entry of the last chunk, it returns to the first entry of the first chunk.

The store is split into banks selected by the low address bits. Successive entries of one queue therefore land in successive banks, and each bank accepts one write and one read per clock. An occupancy count per queue separates full from empty. Illegal requests are refused and reported for one cycle. The defaults are scaled down for test: 4 queues, 4 regions of 8 chunks, 4 entries per chunk (128 entries in all), 8 banks and 8-bit data.

Top module: `qring_mgr`

## Requirements
- R1: While reset is high and in the first cycle after it, every queue reads empty (q_empty all ones) and not full, and push_ack, push_rej, pop_ack and pop_rej are low.
- R2: A cfg_we pulse loads the queue named by cfg_qid. The enable is bit 63, the region base is bits [2*CIW +: RW], the last chunk is bits [CIW +: CIW] and the first chunk is bits [0 +: CIW]. With the defaults (CIW=3, RW=2) these are base [7:6], last [5:3] and first [2:0]. The queue is usable only when it is enabled and last >= first. Loading resets both offsets to the first entry of the first chunk and clears the count, so the queue reads empty in the next cycle.
- R3: An accepted push raises push_ack in the next cycle. push_addr then shows {base, write offset}, meaning base*2^(CIW+CHW) + offset, and the data is written there.
- R4: An accepted pop raises pop_ack in the next cycle. pop_addr then shows {base, read offset}, and pop_data shows the entry stored there, so each queue is first in, first out.
- R5: After an access at offset last*2^CHW + 2^CHW - 1, the next access to that queue uses offset first*2^CHW. At any other offset, the next access uses offset+1.
- R6: A queue is full when its count equals (last-first+1)*2^CHW. A push to a full queue is refused (push_rej next cycle) unless a legal pop to the same queue is issued in the same cycle. q_full and q_empty are never both high for one queue.
- R7: A pop from a queue whose count is zero is refused (pop_rej next cycle), even if a push to that queue is issued in the same cycle.
- R8: A push or pop to a queue that is disabled or has last < first is refused. A push or pop to the queue being loaded by cfg_we in the same cycle is also refused. A refused access changes no queue state.
- R9: A push and a pop to the same queue in one cycle are both accepted when each is legal, and the count is unchanged. If that queue is full, the pop returns the entry that was stored before the write. A push and a pop to different queues in one cycle are both served.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Load a queue configuration word |
| cfg_qid | input | QW | Queue being configured |
| cfg_word | input | 64 | Configuration word |
| push_vld | input | 1 | Push request |
| push_qid | input | QW | Queue to push |
| push_data | input | DW | Data to push |
| pop_vld | input | 1 | Pop request |
| pop_qid | input | QW | Queue to pop |
| push_ack | output | 1 | Previous push accepted |
| push_rej | output | 1 | Previous push refused |
| push_addr | output | AW | Store address of the previous push |
| pop_ack | output | 1 | Previous pop accepted |
| pop_rej | output | 1 | Previous pop refused |
| pop_addr | output | AW | Store address of the previous pop |
| pop_data | output | DW | Data of the previous accepted pop |
| q_full | output | NQ | Per-queue full flag |
| q_empty | output | NQ | Per-queue empty flag |

## Verification
The bench sweeps every legal pair of first and last chunk over several region bases. It overfills each queue, interleaves pushes with pops, and drains the queue past empty. This exposes an offset that wraps at a power of two or at the region edge instead of at the last chunk; such a design would write outside the queue's run and return wrong data. It also drives paired push and pop on a full queue, which a design that compares head and tail pointers alone, or that reads after writing, would refuse or answer with the new data. It also covers a configuration load colliding with an access to the same queue and an inverted chunk range; a design that mishandles these would corrupt a freshly reset queue or serve a queue that has no storage.

// File: rtl/qring_pkg.sv
package qring_pkg;
  localparam int CFG_W  = 64;
  localparam int EN_BIT = 63;
  typedef logic [CFG_W-1:0] cfg_word_t;
endpackage

// File: rtl/qring_addr_gen.sv
// Forms the physical address of a queue slot and the slot offset after it.
module qring_addr_gen #(
  parameter int RW  = 2,
  parameter int CIW = 3,
  parameter int CHW = 2,
  localparam int OFF_W = CIW + CHW,
  localparam int AW    = RW + OFF_W
) (
  input  logic [RW-1:0]    base,
  input  logic [CIW-1:0]   first,
  input  logic [CIW-1:0]   last,
  input  logic [OFF_W-1:0] ptr,
  output logic [AW-1:0]    phys,
  output logic [OFF_W-1:0] nxt
);
  logic at_end;
  assign phys   = {base, ptr};
  assign at_end = (ptr == {last, {CHW{1'b1}}});
  assign nxt    = at_end ? {first, {CHW{1'b0}}} : ptr + OFF_W'(1);
endmodule

// File: rtl/qring_bank.sv
// One bank of the shared store: one write and one read per clock, read-first.
module qring_bank #(
  parameter int DW    = 8,
  parameter int ROW_W = 4
) (
  input  logic             clk,
  input  logic             we,
  input  logic [ROW_W-1:0] waddr,
  input  logic [DW-1:0]    wdata,
  input  logic             re,
  input  logic [ROW_W-1:0] raddr,
  output logic [DW-1:0]    rdata
);
  logic [DW-1:0] mem [2**ROW_W];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/qring_mgr.sv
module qring_mgr
  import qring_pkg::*;
#(
  parameter int NQ  = 4,
  parameter int DW  = 8,
  parameter int RW  = 2,
  parameter int CIW = 3,
  parameter int CHW = 2,
  parameter int BKW = 3,
  localparam int QW    = $clog2(NQ),
  localparam int OFF_W = CIW + CHW,
  localparam int AW    = RW + OFF_W,
  localparam int CNT_W = OFF_W + 1,
  localparam int NB    = 2 ** BKW,
  localparam int ROW_W = AW - BKW,
  localparam int BASE_LSB = 2 * CIW,
  localparam int LAST_LSB = CIW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic [QW-1:0] cfg_qid,
  input  logic [63:0]   cfg_word,
  input  logic          push_vld,
  input  logic [QW-1:0] push_qid,
  input  logic [DW-1:0] push_data,
  input  logic          pop_vld,
  input  logic [QW-1:0] pop_qid,
  output logic          push_ack,
  output logic          push_rej,
  output logic [AW-1:0] push_addr,
  output logic          pop_ack,
  output logic          pop_rej,
  output logic [AW-1:0] pop_addr,
  output logic [DW-1:0] pop_data,
  output logic [NQ-1:0] q_full,
  output logic [NQ-1:0] q_empty
);
  // per-queue state
  logic              q_en    [NQ];
  logic [RW-1:0]     q_base  [NQ];
  logic [CIW-1:0]    q_first [NQ];
  logic [CIW-1:0]    q_last  [NQ];
  logic [OFF_W-1:0]  q_head  [NQ];
  logic [OFF_W-1:0]  q_tail  [NQ];
  logic [CNT_W-1:0]  q_cnt   [NQ];
  logic [NQ-1:0]     q_ok;

  cfg_word_t cfg_in;
  logic      cfg_unused;
  assign cfg_in     = cfg_word;
  assign cfg_unused = ^cfg_in[EN_BIT-1:BASE_LSB+RW];

  // usable / full / empty per queue
  for (genvar i = 0; i < NQ; i++) begin : g_stat
    logic [CNT_W-1:0] cap;
    assign cap        = (CNT_W'(q_last[i]) - CNT_W'(q_first[i]) + CNT_W'(1)) << CHW;
    assign q_ok[i]    = q_en[i] && (q_last[i] >= q_first[i]);
    assign q_full[i]  = q_ok[i] && (q_cnt[i] == cap);
    assign q_empty[i] = (q_cnt[i] == '0);
  end

  // request qualification
  logic push_hit, pop_hit, push_go, pop_go;
  assign push_hit = cfg_we && (cfg_qid == push_qid);
  assign pop_hit  = cfg_we && (cfg_qid == pop_qid);
  assign pop_go   = pop_vld && q_ok[pop_qid] && !q_empty[pop_qid] && !pop_hit;
  assign push_go  = push_vld && q_ok[push_qid] && !push_hit &&
                    (!q_full[push_qid] || (pop_go && pop_qid == push_qid));

  // address generation for the two access paths
  logic [AW-1:0]    push_phys, pop_phys;
  logic [OFF_W-1:0] push_nxt, pop_nxt;

  qring_addr_gen #(.RW(RW), .CIW(CIW), .CHW(CHW)) u_wr_addr (
    .base(q_base[push_qid]), .first(q_first[push_qid]), .last(q_last[push_qid]),
    .ptr(q_tail[push_qid]), .phys(push_phys), .nxt(push_nxt)
  );

  qring_addr_gen #(.RW(RW), .CIW(CIW), .CHW(CHW)) u_rd_addr (
    .base(q_base[pop_qid]), .first(q_first[pop_qid]), .last(q_last[pop_qid]),
    .ptr(q_head[pop_qid]), .phys(pop_phys), .nxt(pop_nxt)
  );

  // banked store, bank chosen by low address bits
  logic [DW-1:0]  bank_rd [NB];
  logic [BKW-1:0] rd_bank_q;

  for (genvar b = 0; b < NB; b++) begin : g_bank
    qring_bank #(.DW(DW), .ROW_W(ROW_W)) u_bank (
      .clk   (clk),
      .we    (push_go && (push_phys[BKW-1:0] == BKW'(b))),
      .waddr (push_phys[AW-1:BKW]),
      .wdata (push_data),
      .re    (pop_go && (pop_phys[BKW-1:0] == BKW'(b))),
      .raddr (pop_phys[AW-1:BKW]),
      .rdata (bank_rd[b])
    );
  end

  assign pop_data = bank_rd[rd_bank_q];

  // queue state update
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NQ; i++) begin
        q_en[i]    <= 1'b0;
        q_base[i]  <= '0;
        q_first[i] <= '0;
        q_last[i]  <= '0;
        q_head[i]  <= '0;
        q_tail[i]  <= '0;
        q_cnt[i]   <= '0;
      end
    end else begin
      for (int i = 0; i < NQ; i++) begin
        if (cfg_we && cfg_qid == QW'(i)) begin
          q_en[i]    <= cfg_in[EN_BIT];
          q_base[i]  <= cfg_in[BASE_LSB +: RW];
          q_last[i]  <= cfg_in[LAST_LSB +: CIW];
          q_first[i] <= cfg_in[0 +: CIW];
          q_head[i]  <= {cfg_in[0 +: CIW], {CHW{1'b0}}};
          q_tail[i]  <= {cfg_in[0 +: CIW], {CHW{1'b0}}};
          q_cnt[i]   <= '0;
        end else begin
          if (push_go && push_qid == QW'(i)) q_tail[i] <= push_nxt;
          if (pop_go && pop_qid == QW'(i))   q_head[i] <= pop_nxt;
          if ((push_go && push_qid == QW'(i)) && !(pop_go && pop_qid == QW'(i)))
            q_cnt[i] <= q_cnt[i] + CNT_W'(1);
          else if (!(push_go && push_qid == QW'(i)) && (pop_go && pop_qid == QW'(i)))
            q_cnt[i] <= q_cnt[i] - CNT_W'(1);
        end
      end
    end
  end

  // registered responses
  always_ff @(posedge clk) begin
    if (rst) begin
      push_ack  <= 1'b0;
      push_rej  <= 1'b0;
      pop_ack   <= 1'b0;
      pop_rej   <= 1'b0;
      push_addr <= '0;
      pop_addr  <= '0;
      rd_bank_q <= '0;
    end else begin
      push_ack  <= push_go;
      push_rej  <= push_vld && !push_go;
      pop_ack   <= pop_go;
      pop_rej   <= pop_vld && !pop_go;
      push_addr <= push_phys;
      pop_addr  <= pop_phys;
      if (pop_go) rd_bank_q <= pop_phys[BKW-1:0];
    end
  end
endmodule

// File: rtl/qring_mgr_chk.sv
module qring_mgr_chk #(
  parameter int NQ = 4,
  parameter int QW = 2
) (
  input logic          clk,
  input logic          rst,
  input logic          cfg_we,
  input logic [QW-1:0] cfg_qid,
  input logic          push_vld,
  input logic [QW-1:0] push_qid,
  input logic          pop_vld,
  input logic [QW-1:0] pop_qid,
  input logic          push_ack,
  input logic          push_rej,
  input logic          pop_ack,
  input logic          pop_rej,
  input logic [NQ-1:0] q_full,
  input logic [NQ-1:0] q_empty
);
  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (q_empty == '1 && q_full == '0 && !push_ack && !pop_ack && !push_rej && !pop_rej));

  assert_cfg_clears_R2: assert property (@(posedge clk) disable iff (rst)
    cfg_we |=> q_empty[$past(cfg_qid)]);

  assert_push_outcome_R3: assert property (@(posedge clk) disable iff (rst)
    push_vld |=> (push_ack != push_rej));

  assert_pop_outcome_R4: assert property (@(posedge clk) disable iff (rst)
    pop_vld |=> (pop_ack != pop_rej));

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (rst)
    (push_vld && q_full[push_qid] && !(pop_vld && pop_qid == push_qid)) |=> push_rej);

  assert_flags_excl_R6: assert property (@(posedge clk) disable iff (rst)
    (q_full & q_empty) == '0);

  assert_no_underflow_R7: assert property (@(posedge clk) disable iff (rst)
    (pop_vld && q_empty[pop_qid]) |=> pop_rej);

  assert_cfg_collide_R8: assert property (@(posedge clk) disable iff (rst)
    (push_vld && cfg_we && cfg_qid == push_qid) |=> push_rej);

  assert_full_pair_R9: assert property (@(posedge clk) disable iff (rst)
    (push_vld && pop_vld && push_qid == pop_qid && q_full[push_qid] &&
     !(cfg_we && cfg_qid == push_qid)) |=> (push_ack && pop_ack));
endmodule

bind qring_mgr qring_mgr_chk #(.NQ(NQ), .QW(QW)) u_chk (
  .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_qid(cfg_qid),
  .push_vld(push_vld), .push_qid(push_qid), .pop_vld(pop_vld), .pop_qid(pop_qid),
  .push_ack(push_ack), .push_rej(push_rej), .pop_ack(pop_ack), .pop_rej(pop_rej),
  .q_full(q_full), .q_empty(q_empty)
);

// File: tb/qring_mgr_bench.sv
`timescale 1ns/1ps
module qring_mgr_bench;
  localparam int NQ = 4, DW = 8, QW = 2, AW = 7, CH = 4, REG = 32, TOT = 128;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst;
  logic          cfg_we;
  logic [QW-1:0] cfg_qid;
  logic [63:0]   cfg_word;
  logic          push_vld, pop_vld;
  logic [QW-1:0] push_qid, pop_qid;
  logic [DW-1:0] push_data;
  logic          push_ack, push_rej, pop_ack, pop_rej;
  logic [AW-1:0] push_addr, pop_addr;
  logic [DW-1:0] pop_data;
  logic [NQ-1:0] q_full, q_empty;

  qring_mgr u_qring_mgr (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_qid(cfg_qid), .cfg_word(cfg_word),
    .push_vld(push_vld), .push_qid(push_qid), .push_data(push_data),
    .pop_vld(pop_vld), .pop_qid(pop_qid),
    .push_ack(push_ack), .push_rej(push_rej), .push_addr(push_addr),
    .pop_ack(pop_ack), .pop_rej(pop_rej), .pop_addr(pop_addr), .pop_data(pop_data),
    .q_full(q_full), .q_empty(q_empty)
  );

  int checks = 0, failures = 0;
  bit done = 0;

  // bench model
  bit m_ok [NQ];
  int m_base [NQ], m_first [NQ], m_last [NQ], m_head [NQ], m_tail [NQ], m_cnt [NQ];
  int m_mem [TOT];
  int seed_data = 1;

  function automatic int cap_of(int q);
    return (m_last[q] - m_first[q] + 1) * CH;
  endfunction

  function automatic int adv(int q, int p);
    if (p == m_last[q] * CH + CH - 1) return m_first[q] * CH;
    return p + 1;
  endfunction

  function automatic logic [63:0] mkcfg(bit en, int base, int first, int last);
    logic [63:0] w;
    w = 64'h0;
    w[63]  = en;
    w[7:6] = base[1:0];
    w[5:3] = last[2:0];
    w[2:0] = first[2:0];
    w[40]  = 1'b1;  // unrelated bit, must not matter
    return w;
  endfunction

  task automatic chk(bit ok, string msg, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", msg, act, exp);
    end
  endtask

  task automatic step(bit cw, int cq, logic [63:0] cwd, bit pv, int pq, int pd,
                      bit ov, int oq, string tag);
    bit e_push, e_pop;
    int e_paddr, e_oaddr, e_data;
    @(negedge clk);
    cfg_we = cw; cfg_qid = QW'(cq); cfg_word = cwd;
    push_vld = pv; push_qid = QW'(pq); push_data = DW'(pd);
    pop_vld = ov; pop_qid = QW'(oq);
    e_pop  = ov && m_ok[oq] && m_cnt[oq] > 0 && !(cw && cq == oq);
    e_push = pv && m_ok[pq] && !(cw && cq == pq) &&
             (m_cnt[pq] < cap_of(pq) || (e_pop && oq == pq));
    e_paddr = m_base[pq] * REG + m_tail[pq];
    e_oaddr = m_base[oq] * REG + m_head[oq];
    e_data  = m_mem[e_oaddr];
    @(posedge clk);
    #1;
    chk(push_ack === e_push, {tag, " push_ack"}, int'(push_ack), int'(e_push));
    chk(push_rej === (pv && !e_push), {tag, " push_rej"}, int'(push_rej), int'(pv && !e_push));
    chk(pop_ack === e_pop, {tag, " pop_ack"}, int'(pop_ack), int'(e_pop));
    chk(pop_rej === (ov && !e_pop), {tag, " pop_rej"}, int'(pop_rej), int'(ov && !e_pop));
    if (e_push) chk(push_addr === AW'(e_paddr), {tag, " push_addr"}, int'(push_addr), e_paddr);
    if (e_pop) begin
      chk(pop_addr === AW'(e_oaddr), {tag, " pop_addr"}, int'(pop_addr), e_oaddr);
      chk(pop_data === DW'(e_data), {tag, " pop_data"}, int'(pop_data), e_data);
    end
    // model update
    if (e_push) begin
      m_mem[e_paddr] = pd & 8'hff;
      m_tail[pq] = adv(pq, m_tail[pq]);
      m_cnt[pq]++;
    end
    if (e_pop) begin
      m_head[oq] = adv(oq, m_head[oq]);
      m_cnt[oq]--;
    end
    if (cw) begin
      m_base[cq]  = int'(cwd[7:6]);
      m_last[cq]  = int'(cwd[5:3]);
      m_first[cq] = int'(cwd[2:0]);
      m_ok[cq]    = cwd[63] && (m_last[cq] >= m_first[cq]);
      m_head[cq]  = m_first[cq] * CH;
      m_tail[cq]  = m_first[cq] * CH;
      m_cnt[cq]   = 0;
    end
    for (int q = 0; q < NQ; q++) begin
      bit ef, ee;
      ef = m_ok[q] && m_cnt[q] == cap_of(q);
      ee = m_cnt[q] == 0;
      chk(q_full[q] === ef, {tag, " R6 q_full"}, int'(q_full[q]), int'(ef));
      chk(q_empty[q] === ee, {tag, " R6 q_empty"}, int'(q_empty[q]), int'(ee));
    end
    cfg_we = 0; push_vld = 0; pop_vld = 0;
  endtask

  task automatic do_cfg(int q, bit en, int b, int f, int l, string tag);
    step(1, q, mkcfg(en, b, f, l), 0, 0, 0, 0, 0, tag);
  endtask
  task automatic do_push(int q, string tag);
    seed_data = (seed_data * 37 + 11) % 251;
    step(0, 0, 64'h0, 1, q, seed_data, 0, 0, tag);
  endtask
  task automatic do_pop(int q, string tag);
    step(0, 0, 64'h0, 0, 0, 0, 1, q, tag);
  endtask
  task automatic do_pair(int pq, int oq, string tag);
    seed_data = (seed_data * 37 + 11) % 251;
    step(0, 0, 64'h0, 1, pq, seed_data, 1, oq, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int q = 0; q < NQ; q++) begin
      m_ok[q] = 0; m_base[q] = 0; m_first[q] = 0; m_last[q] = 0;
      m_head[q] = 0; m_tail[q] = 0; m_cnt[q] = 0;
    end
    for (int a = 0; a < TOT; a++) m_mem[a] = 0;
    rst = 1; cfg_we = 0; cfg_qid = 0; cfg_word = 0;
    push_vld = 0; push_qid = 0; push_data = 0; pop_vld = 0; pop_qid = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    // R1 reset state
    chk(q_empty === 4'hf, "R1 q_empty after reset", int'(q_empty), 15);
    chk(q_full === 4'h0, "R1 q_full after reset", int'(q_full), 0);
    chk(!push_ack && !pop_ack && !push_rej && !pop_rej, "R1 responses after reset", 1, 0);

    // R8 disabled queues refuse everything
    do_push(1, "R8 disabled");
    do_pop(1, "R8 disabled");

    // R2 load queue 0: region 1, chunks 2..3 (8 entries)
    do_cfg(0, 1, 1, 2, 3, "R2 load");
    // R3 fill, R6 overfill refused
    for (int k = 0; k < 9; k++) do_push(0, "R3 R6 fill");
    // R4 partial drain, R5 wrap of the write offset
    for (int k = 0; k < 4; k++) do_pop(0, "R4 drain");
    for (int k = 0; k < 4; k++) do_push(0, "R5 wrap push");
    // R9 paired push/pop on a full queue
    for (int k = 0; k < 5; k++) do_pair(0, 0, "R9 full pair");
    // R7 drain past empty, and paired push with pop on an empty queue
    for (int k = 0; k < 9; k++) do_pop(0, "R7 drain");
    do_pair(0, 0, "R7 pop empty with push");

    // R2 R8 inverted range is unusable
    do_cfg(2, 1, 2, 5, 1, "R2 inverted");
    do_push(2, "R8 inverted");
    do_pop(2, "R8 inverted");

    // R9 different queues in one cycle
    do_cfg(1, 1, 3, 0, 0, "R2 load q1");
    do_push(1, "R9 prep");
    do_pair(1, 0, "R9 cross queue");
    do_pair(0, 1, "R9 cross queue");

    // R2 R8 config colliding with access, reload clears
    do_push(0, "R2 prep");
    step(1, 0, mkcfg(1, 1, 2, 3), 1, 0, 99, 1, 0, "R8 cfg collide");
    do_pop(0, "R2 reloaded empty");
    do_push(0, "R2 reloaded first slot");
    do_cfg(0, 0, 1, 2, 3, "R2 disable");
    do_push(0, "R8 after disable");

    // near-exhaustive sweep of chunk ranges on queue 3 (R5 R6 R4)
    for (int f = 0; f < 8; f++) begin
      for (int l = f; l < 8; l++) begin
        int c;
        c = (l - f + 1) * CH;
        do_cfg(3, 1, (f + l) % 4, f, l, "R5 sweep cfg");
        for (int k = 0; k < c / 2 + 1; k++) do_push(3, "R5 sweep push");
        for (int k = 0; k < c / 2; k++) do_pop(3, "R5 sweep pop");
        for (int k = 0; k < c + 1; k++) do_push(3, "R6 sweep fill");
        for (int k = 0; k < 3; k++) do_pair(3, 3, "R9 sweep pair");
        for (int k = 0; k < c + 1; k++) do_pop(3, "R4 sweep drain");
      end
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule